// File: doc/BRIEF.md
# Packed Lane Logical Right Shifter

This block shifts every element of a 128-bit vector right by a common count and fills the vacated high bits with zeros. The elements are 16, 32 or 64 bits wide, so a vector holds eight, four or two of them. Bits never pass from one element into the next.

The count comes from one of two places. It can be an 8-bit immediate, or it can be the low 64 bits of a 128-bit count vector. The count is compared as a full unsigned value, so any count at or beyond the element width clears the element rather than wrapping around. A per-element write mask picks, for each element, either the shifted value or a fallback. The fallback is the old destination element in merge mode and zero in zeroing mode. In immediate mode a broadcast option copies element 0 of the source into every element position before the shift.

Operands enter through a valid/ready stream and results leave through a second valid/ready stream. A parameter adds an output register. When present, this register holds a result while the consumer withholds ready and accepts a new operand only when its slot is free or is being emptied in the same cycle. Without the register, the path is combinational: valid and ready pass straight through.

Top module: `lsr_packed_shift`

## Requirements
- R1: Each element is shifted right logically by the count, with zeros entering at its top bit and no bit crossing an element boundary. Element j occupies bits [j*W+W-1 : j*W] for element width W.
- R2: `lane_sz` selects the element width: 2'b00 gives 16 bits, 2'b01 gives 32 bits, 2'b10 gives 64 bits, and the spare code 2'b11 also gives 64 bits.
- R3: A count greater than W-1 (above 15, 31 or 63) makes every shifted element zero.
- R4: With `use_imm`=0 the count is `cnt_vec[63:0]`, compared as a full 64-bit unsigned value. `cnt_vec[127:64]` has no effect on the result, and a count of 64'h1_0000_0000 clears the elements.
- R5: With `use_imm`=1 the count is the unsigned 8-bit `imm_cnt`, and the rule of R3 applies to it.
- R6: A count of zero passes each unmasked element through unchanged.
- R7: With `mask_en`=0 every element takes its shifted value. With `mask_en`=1, element j takes its shifted value only when `mask[j]` is 1. Only mask bits 0..7, 0..3 or 0..1 are used for 16-, 32- or 64-bit elements.
- R8: A masked-off element takes the `old_dst` element when `zero_mode`=0 and becomes zero when `zero_mode`=1.
- R9: With `bcast`=1 and `use_imm`=1, source element 0 at the selected width is copied into every element before the shift. With `use_imm`=0, `bcast` has no effect.
- R10: With the output register, a result appears on the clock edge that follows acceptance (`in_valid` and `in_ready` both 1). `in_ready` equals `!out_valid || out_ready`, and while `out_valid` is 1 and `out_ready` is 0 the result stays stable.
- R11: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Block can accept an operand set |
| src | input | 128 | Vector to be shifted |
| old_dst | input | 128 | Previous destination, used for merged elements |
| cnt_vec | input | 128 | Count vector; only bits 63:0 are used |
| imm_cnt | input | 8 | Immediate count |
| use_imm | input | 1 | 1 selects the immediate count |
| lane_sz | input | 2 | Element width code |
| mask | input | 8 | Per-element write mask |
| mask_en | input | 1 | 1 enables masking |
| zero_mode | input | 1 | 1 zeroes masked-off elements, 0 merges them |
| bcast | input | 1 | Replicate element 0 (immediate mode only) |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 128 | Shifted and masked vector |

## Verification
With the default output register, every result is due exactly one rising edge after the edge at which its operand set is accepted. It then stays on `result` until the edge at which `out_ready` is seen high. The driver changes inputs and reads `in_ready` just after falling edges. The monitor compares `result` against the oldest queued expectation at a falling edge, and only when `out_valid` and `out_ready` are both high, because that falling edge comes just before the rising edge that completes the transfer. While the consumer stalls, the monitor also compares each held result with its value one falling edge earlier.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [1:0] {
    LSZ_16  = 2'b00,
    LSZ_32  = 2'b01,
    LSZ_64  = 2'b10,
    LSZ_64X = 2'b11
  } lane_sz_e;

  localparam int CHUNK_W = 16;
  localparam int CNT_W   = 64;
  localparam int IMM_W   = 8;
  localparam int AMT_W   = 6;
endpackage

// File: rtl/lsr_count_sel.sv
module lsr_count_sel
  import lsr_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic [VW-1:0]    cnt_vec,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic             use_imm,
  output logic [AMT_W-1:0] amt,
  output logic             over16,
  output logic             over32,
  output logic             over64
);
  logic [CNT_W-1:0] cnt;

  // the vector count only contributes its low CNT_W bits
  always_comb begin
    if (use_imm) cnt = {{(CNT_W-IMM_W){1'b0}}, imm_cnt};
    else         cnt = cnt_vec[CNT_W-1:0];
  end

  // over-range tests look at every upper bit, so large counts never wrap
  assign over16 = |cnt[CNT_W-1:4];
  assign over32 = |cnt[CNT_W-1:5];
  assign over64 = |cnt[CNT_W-1:6];
  assign amt    = cnt[AMT_W-1:0];
endmodule

// File: rtl/lsr_lane_shift.sv
module lsr_lane_shift
  import lsr_pkg::*;
#(
  parameter int VW = 128
) (
  input  logic [VW-1:0]    data,
  input  logic [AMT_W-1:0] amt,
  input  logic             over16,
  input  logic             over32,
  input  logic             over64,
  input  lane_sz_e         lane_sz,
  output logic [VW-1:0]    shifted
);
  localparam int N16 = VW / 16;
  localparam int N32 = VW / 32;
  localparam int N64 = VW / 64;

  logic [VW-1:0] s16, s32, s64;

  for (genvar k = 0; k < N16; k++) begin : g_l16
    assign s16[k*16 +: 16] = over16 ? 16'd0 : (data[k*16 +: 16] >> amt[3:0]);
  end
  for (genvar k = 0; k < N32; k++) begin : g_l32
    assign s32[k*32 +: 32] = over32 ? 32'd0 : (data[k*32 +: 32] >> amt[4:0]);
  end
  for (genvar k = 0; k < N64; k++) begin : g_l64
    assign s64[k*64 +: 64] = over64 ? 64'd0 : (data[k*64 +: 64] >> amt[5:0]);
  end

  always_comb begin
    unique case (lane_sz)
      LSZ_16:  shifted = s16;
      LSZ_32:  shifted = s32;
      default: shifted = s64;
    endcase
  end
endmodule

// File: rtl/lsr_mask_apply.sv
module lsr_mask_apply
  import lsr_pkg::*;
#(
  parameter int VW = 128,
  localparam int MW = VW / CHUNK_W
) (
  input  logic [VW-1:0] shifted,
  input  logic [VW-1:0] old_dst,
  input  logic [MW-1:0] mask,
  input  logic          mask_en,
  input  logic          zero_mode,
  input  lane_sz_e      lane_sz,
  output logic [VW-1:0] res
);
  // each 16-bit chunk looks up the mask bit of the element that owns it
  for (genvar k = 0; k < MW; k++) begin : g_chunk
    logic mbit, keep;
    always_comb begin
      unique case (lane_sz)
        LSZ_16:  mbit = mask[k];
        LSZ_32:  mbit = mask[k/2];
        default: mbit = mask[k/4];
      endcase
      keep = !mask_en || mbit;
    end
    assign res[k*CHUNK_W +: CHUNK_W] =
      keep      ? shifted[k*CHUNK_W +: CHUNK_W] :
      zero_mode ? {CHUNK_W{1'b0}}                :
                  old_dst[k*CHUNK_W +: CHUNK_W];
  end
endmodule

// File: rtl/lsr_packed_shift.sv
module lsr_packed_shift
  import lsr_pkg::*;
#(
  parameter int VW      = 128,
  parameter bit REG_OUT = 1'b1,
  localparam int MW = VW / CHUNK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VW-1:0]    src,
  input  logic [VW-1:0]    old_dst,
  input  logic [VW-1:0]    cnt_vec,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic             use_imm,
  input  logic [1:0]       lane_sz,
  input  logic [MW-1:0]    mask,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic             bcast,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VW-1:0]    result
);
  lane_sz_e sz;
  assign sz = lane_sz_e'(lane_sz);

  // broadcast: every chunk repeats the chunks of element 0 (immediate mode only)
  logic [VW-1:0] bc16, bc32, bc64, src_eff;
  for (genvar k = 0; k < MW; k++) begin : g_bc
    assign bc16[k*CHUNK_W +: CHUNK_W] = src[0 +: CHUNK_W];
    assign bc32[k*CHUNK_W +: CHUNK_W] = src[(k%2)*CHUNK_W +: CHUNK_W];
    assign bc64[k*CHUNK_W +: CHUNK_W] = src[(k%4)*CHUNK_W +: CHUNK_W];
  end

  always_comb begin
    if (bcast && use_imm) begin
      unique case (sz)
        LSZ_16:  src_eff = bc16;
        LSZ_32:  src_eff = bc32;
        default: src_eff = bc64;
      endcase
    end else begin
      src_eff = src;
    end
  end

  logic [AMT_W-1:0] amt;
  logic over16, over32, over64;

  lsr_count_sel #(.VW(VW)) u_cnt (
    .cnt_vec (cnt_vec),
    .imm_cnt (imm_cnt),
    .use_imm (use_imm),
    .amt     (amt),
    .over16  (over16),
    .over32  (over32),
    .over64  (over64)
  );

  logic [VW-1:0] shifted;

  lsr_lane_shift #(.VW(VW)) u_shift (
    .data    (src_eff),
    .amt     (amt),
    .over16  (over16),
    .over32  (over32),
    .over64  (over64),
    .lane_sz (sz),
    .shifted (shifted)
  );

  logic [VW-1:0] masked;

  lsr_mask_apply #(.VW(VW)) u_mask (
    .shifted   (shifted),
    .old_dst   (old_dst),
    .mask      (mask),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .lane_sz   (sz),
    .res       (masked)
  );

  if (REG_OUT) begin : g_reg
    logic          v_q;
    logic [VW-1:0] r_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (in_ready) begin
        v_q <= in_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready) r_q <= masked;
    end

    assign out_valid = v_q;
    assign result    = r_q;

    // R10: a stalled result must not move
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(result)));

    // R10: an accepted operand set produces a valid result one edge later
    a_r10_one_edge: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

    // R11: reset empties the output slot
    a_r11_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign result    = masked;
  end

  // R3: a vector count beyond 63 clears every element of the shifter output
  a_r3_over_clears: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !use_imm && (cnt_vec[63:0] > 64'd63)) |-> (shifted == '0));

  // R6: an immediate count of zero, unmasked, leaves the source unchanged
  a_r6_zero_passes: assert property (@(posedge clk) disable iff (rst)
    (in_valid && use_imm && !bcast && !mask_en && (imm_cnt == '0)) |-> (masked == src));

  // R8: zero mode with an empty mask yields an all-zero vector
  a_r8_zero_mode: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && zero_mode && (mask == '0)) |-> (masked == '0));
endmodule

// File: tb/lsr_packed_shift_test.sv
module lsr_packed_shift_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] src = '0, old_dst = '0, cnt_vec = '0;
  logic [7:0]   imm_cnt = '0;
  logic         use_imm = 1'b0;
  logic [1:0]   lane_sz = 2'b00;
  logic [7:0]   mask = '0;
  logic         mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit bp_on  = 1'b0;
  int cyc    = 0;

  typedef struct {
    logic [127:0] v;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsr_packed_shift uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .old_dst(old_dst), .cnt_vec(cnt_vec), .imm_cnt(imm_cnt),
    .use_imm(use_imm), .lane_sz(lane_sz), .mask(mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .bcast(bcast), .out_valid(out_valid),
    .out_ready(out_ready), .result(result)
  );

  // independent reference built from the requirements
  function automatic logic [127:0] model();
    int w, n, ci;
    logic [63:0]  c;
    logic [127:0] r;
    logic         sb, keep;
    w = (lane_sz == 2'b00) ? 16 : (lane_sz == 2'b01) ? 32 : 64;
    n = 128 / w;
    c = use_imm ? {56'd0, imm_cnt} : cnt_vec[63:0];
    ci = (c < 64'(w)) ? int'(c[6:0]) : w;
    r = '0;
    for (int j = 0; j < n; j++) begin
      keep = !mask_en || mask[j];
      for (int b = 0; b < w; b++) begin
        if (b + ci < w)
          sb = (bcast && use_imm) ? src[b + ci] : src[j*w + b + ci];
        else
          sb = 1'b0;
        r[j*w + b] = keep ? sb : (zero_mode ? 1'b0 : old_dst[j*w + b]);
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: inputs change just after a falling edge
  task automatic send(input string tag);
    exp_t e;
    e.v   = model();
    e.tag = tag;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer back-pressure pattern
  always @(negedge clk) begin
    cyc++;
    out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic [127:0] held;
  bit           held_v = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && out_valid && held_v)
        chk(result == held, "R10 stalled result changed", result, held);
      held_v = 1'b0;
      if (!rst && out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected result", result, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(result == e.v, e.tag, result, e.v);
        end
      end else if (!rst && out_valid) begin
        held   = result;
        held_v = 1'b1;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R10 watchdog expired", '0, '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic set_vec(input logic [63:0] c);
    use_imm = 1'b0; cnt_vec = {64'hDEAD_BEEF_0000_0001, c};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11 out_valid after reset", {127'd0, out_valid}, '0);
    chk(in_ready == 1'b1, "R10 in_ready after reset", {127'd0, in_ready}, 128'd1);
    rst = 1'b0;
    @(negedge clk);

    src     = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
    old_dst = 128'h1111_2222_3333_4444_5555_6666_7777_8888;

    for (int s = 0; s < 3; s++) begin
      int w;
      w = 16 << s;
      lane_sz = 2'(s);
      mask_en = 1'b0; bcast = 1'b0;
      set_vec(64'd0);            send("R6 count zero passes");
      set_vec(64'(w - 1));       send("R1 largest legal count");
      set_vec(64'(w));           send("R3 smallest over-range count");
      set_vec(64'd5);            send("R1 shift by 5");
      set_vec(64'h1_0000_0000);  send("R4 large 64-bit count clears");
      use_imm = 1'b1; imm_cnt = 8'd3;            send("R5 immediate count 3");
      imm_cnt = 8'(w);                            send("R5 immediate over-range");
      imm_cnt = 8'd255;                           send("R5 immediate 255 clears");
      imm_cnt = 8'd2; bcast = 1'b1;               send("R9 broadcast element 0");
      use_imm = 1'b0; cnt_vec = {64'd0, 64'd2};   send("R9 broadcast ignored for vector count");
      bcast = 1'b0;
      mask_en = 1'b1; mask = 8'b1010_0101; zero_mode = 1'b0;
      set_vec(64'd1);            send("R8 merge mode keeps old element");
      zero_mode = 1'b1;          send("R8 zero mode clears element");
      mask = 8'hFF;              send("R7 full mask takes shifted values");
      mask = 8'h00; zero_mode = 1'b0;
      send("R7 empty mask merges every element");
    end

    // R4: the upper half of the count vector must not matter
    lane_sz = 2'b00; mask_en = 1'b0;
    use_imm = 1'b0; cnt_vec = {64'hFFFF_FFFF_FFFF_FFFF, 64'd4};
    send("R4 upper count half ignored");
    // R2: the spare size code behaves as 64-bit elements
    lane_sz = 2'b11; cnt_vec = {64'd0, 64'd20};
    send("R2 spare size code as 64-bit");
    lane_sz = 2'b11; cnt_vec = {64'd0, 64'd40};
    send("R2 spare size code, count 40");

    // R10: back-pressure with varied data
    bp_on = 1'b1;
    for (int i = 0; i < 24; i++) begin
      lane_sz = 2'(i % 3);
      src     = {src[126:0], src[127] ^ src[100]};
      use_imm = i[0];
      imm_cnt = 8'(i * 3);
      cnt_vec = {64'hABCD, 64'(i * 5)};
      mask_en = i[1]; mask = 8'(i * 37); zero_mode = i[2];
      send("R10 result under back-pressure");
    end
    bp_on = 1'b0;
    mask_en = 1'b0; use_imm = 1'b0;

    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    rst = 1'b1;
    @(negedge clk);
    #3;
    chk(out_valid == 1'b0, "R11 out_valid after second reset", {127'd0, out_valid}, '0);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule